// File: doc/BRIEF.md
# Multi-Ring Transmit Halt Controller

This block guards the descriptor fetch path of a DMA transmitter that serves three descriptor rings. It keeps one halt flag per ring. It checks every descriptor that a fetch returns, and every bus response, for faults. It picks which ring may fetch next. A halted ring gets no fetch grant until software clears its flag.

A general fault halts every ring at once, whatever the per-ring enables say. These faults are a bus error, an uncorrectable read, a ready descriptor of zero length, or an address outside the mapped window. A fetch that finds no ready descriptor halts only the ring that was granted. A graceful-stop request withholds all grants but never sets a halt flag.

Software reads the halt flags and a sticky error flag from the status word. It clears any of them by writing ones to those bit positions.

Top module: `tx_ring_halt`

## Requirements
- R1: After reset, every halt flag, the sticky error flag (status bit 3) and the error pulse are 0.
- R2: The grant `fetchEn[i]` is never 1 while halt flag i (status bit i, for rings 0, 1 and 2) is set.
- R3: A register write with a 1 in bit i clears that status bit on the next clock edge. A 0 in a bit position leaves that bit unchanged.
- R4: Each of the following sets all three halt flags on the next edge, regardless of ring enables and graceful stop:
  - `busErr`
  - `uncorrErr`
  - a valid descriptor with ready=1 and length=0
  - a valid descriptor whose address has any bit at or above position MAP_BITS (28) set
- R5: A valid descriptor with ready=0 sets the halt flag of the ring granted in that cycle and no other. If no ring is granted, it sets nothing.
- R6: While `gracefulStop` is high, all grants are 0, and the request by itself sets no halt flag.
- R7: A general fault raises `txErrPulse` for exactly the next cycle and sets the sticky error flag (status bit 3). That flag clears by writing 1 to bit 3.
- R8: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: At most one grant is high. It goes to the lowest-numbered ring that is enabled and not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringEn | input | 3 | Per-ring enable |
| gracefulStop | input | 1 | Software request to stop fetching without halting |
| descValid | input | 1 | A fetched descriptor is presented this cycle |
| descReady | input | 1 | Ready flag of the fetched descriptor |
| descLen | input | 16 | Length field of the fetched descriptor |
| descAddr | input | 32 | Buffer address of the fetched descriptor |
| busErr | input | 1 | Bus error on a descriptor or data access |
| uncorrErr | input | 1 | Uncorrectable error on a descriptor or data read |
| regWr | input | 1 | Status register write strobe |
| regWdata | input | 4 | Write-one-to-clear data (bits 0-2 halt, bit 3 error) |
| fetchEn | output | 3 | One-hot fetch grant per ring |
| statusWord | output | 4 | Halt flags in bits 0-2, sticky error flag in bit 3 |
| txErrPulse | output | 1 | One-cycle general-fault event |

## Verification
The bench raises a general fault while all rings are disabled, and again while graceful stop is high. A design that gated halting on the enables or on the stop request would leave the flags clear. It presents a no-ready descriptor during graceful stop, where no ring is granted; a design that defaulted the culprit to ring 0 would halt it wrongly. It clears and sets the same bits in one cycle, which catches a clear-priority register. It also writes zeros and expects no change, which catches a write that overwrites instead of clearing.

// File: rtl/txhalt_pkg.sv
package txhalt_pkg;
  localparam int RING_COUNT = 3;

  typedef struct packed {
    logic [RING_COUNT-1:0] setMask;  // halt bits to set this cycle
    logic                  errEvt;   // general fault seen this cycle
  } haltStrb_t;
endpackage

// File: rtl/txhalt_ctrl.sv
module txhalt_ctrl
  import txhalt_pkg::*;
#(
  parameter int NR       = RING_COUNT,
  parameter int LEN_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int MAP_BITS = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NR-1:0]     haltQ,
  input  logic [NR-1:0]     ringEn,
  input  logic              gracefulStop,
  input  logic              descValid,
  input  logic              descReady,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic              busErr,
  input  logic              uncorrErr,
  output logic [NR-1:0]     fetchEn,
  output haltStrb_t         strb
);
  localparam int HI_W = ADDR_W - MAP_BITS;

  logic [NR-1:0] eligible;
  logic          addrBad;
  logic          zeroLen;
  logic          genErr;
  logic          noReady;

  assign eligible = ringEn & ~haltQ & {NR{~gracefulStop}};

  // fixed priority, lowest ring number wins
  always_comb begin
    fetchEn = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (eligible[i]) fetchEn = NR'(1) << i;
    end
  end

  generate
    if (HI_W > 0) begin : g_addrChk
      assign addrBad = |descAddr[ADDR_W-1:MAP_BITS];
    end else begin : g_noAddrChk
      assign addrBad = 1'b0;
    end
  endgenerate

  assign zeroLen = descReady && (descLen == '0);
  assign genErr  = busErr || uncorrErr || (descValid && (zeroLen || addrBad));
  assign noReady = descValid && !descReady;

  always_comb begin
    strb.errEvt  = genErr;
    strb.setMask = genErr ? {NR{1'b1}} : (noReady ? fetchEn : '0);
  end

  // R2: a halted ring is never granted
  a_r2_no_grant_halted: assert property (@(posedge clk) disable iff (!rstN)
    (fetchEn & haltQ) == '0);
  // R6: graceful stop withholds all grants
  a_r6_stop_no_grant: assert property (@(posedge clk) disable iff (!rstN)
    gracefulStop |-> fetchEn == '0);
  // R9: at most one grant
  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fetchEn));
endmodule

// File: rtl/txhalt_dp.sv
module txhalt_dp
  import txhalt_pkg::*;
#(
  parameter int NR = RING_COUNT
) (
  input  logic          clk,
  input  logic          rstN,
  input  haltStrb_t     strb,
  input  logic          regWr,
  input  logic [NR:0]   regWdata,
  output logic [NR-1:0] haltQ,
  output logic          errSticky,
  output logic          errPulse
);
  logic [NR:0] clrMask;

  assign clrMask = regWr ? regWdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltQ     <= '0;
      errSticky <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      haltQ     <= (haltQ & ~clrMask[NR-1:0]) | strb.setMask;
      errSticky <= (errSticky & ~clrMask[NR]) | strb.errEvt;
      errPulse  <= strb.errEvt;
    end
  end

  // R8: a set lands even when a clear hits the same bit
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.setMask != '0 |=> (haltQ & $past(strb.setMask)) == $past(strb.setMask));
  // R3: a flag without set or clear holds its value
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!regWr && strb.setMask == '0) |=> $stable(haltQ));
  // R7: sticky flag follows a fault
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    strb.errEvt |=> errSticky && errPulse);
endmodule

// File: rtl/tx_ring_halt.sv
module tx_ring_halt
  import txhalt_pkg::*;
#(
  parameter int NR       = RING_COUNT,
  parameter int LEN_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int MAP_BITS = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NR-1:0]     ringEn,
  input  logic              gracefulStop,
  input  logic              descValid,
  input  logic              descReady,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic              busErr,
  input  logic              uncorrErr,
  input  logic              regWr,
  input  logic [NR:0]       regWdata,
  output logic [NR-1:0]     fetchEn,
  output logic [NR:0]       statusWord,
  output logic              txErrPulse
);
  haltStrb_t     strb;
  logic [NR-1:0] haltQ;
  logic          errSticky;

  txhalt_ctrl #(.NR(NR), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .MAP_BITS(MAP_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .haltQ(haltQ), .ringEn(ringEn),
    .gracefulStop(gracefulStop), .descValid(descValid), .descReady(descReady),
    .descLen(descLen), .descAddr(descAddr), .busErr(busErr),
    .uncorrErr(uncorrErr), .fetchEn(fetchEn), .strb(strb)
  );

  txhalt_dp #(.NR(NR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWr(regWr), .regWdata(regWdata),
    .haltQ(haltQ), .errSticky(errSticky), .errPulse(txErrPulse)
  );

  assign statusWord = {errSticky, haltQ};

  // R4: bus or uncorrectable error halts every ring
  a_r4_fault_halts_all: assert property (@(posedge clk) disable iff (!rstN)
    (busErr || uncorrErr) |=> &statusWord[NR-1:0]);
  // R1: state is clear in the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> statusWord == '0 && !txErrPulse);
endmodule

// File: tb/tx_ring_halt_tb.sv
module tx_ring_halt_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [2:0]  ringEn = 0;
  logic        gracefulStop = 0;
  logic        descValid = 0;
  logic        descReady = 0;
  logic [15:0] descLen = 0;
  logic [31:0] descAddr = 0;
  logic        busErr = 0;
  logic        uncorrErr = 0;
  logic        regWr = 0;
  logic [3:0]  regWdata = 0;
  logic [2:0]  fetchEn;
  logic [3:0]  statusWord;
  logic        txErrPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0] status;
    logic       pulse;
    string      tag;
  } item_t;
  item_t sbq[$];

  logic [2:0] mHalt = 0;
  logic       mSticky = 0;

  always #5 clk = ~clk;

  tx_ring_halt u_dut (
    .clk(clk), .rstN(rstN), .ringEn(ringEn), .gracefulStop(gracefulStop),
    .descValid(descValid), .descReady(descReady), .descLen(descLen),
    .descAddr(descAddr), .busErr(busErr), .uncorrErr(uncorrErr),
    .regWr(regWr), .regWdata(regWdata), .fetchEn(fetchEn),
    .statusWord(statusWord), .txErrPulse(txErrPulse)
  );

  function automatic logic [2:0] modelGrant();
    logic [2:0] g = 0;
    if (!gracefulStop) begin
      for (int i = 2; i >= 0; i--)
        if (ringEn[i] && !mHalt[i]) g = 3'(1) << i;
    end
    return g;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: inputs already set by caller; check grant, push expected state
  task automatic step(input string tag);
    logic [2:0] g;
    logic       gen;
    logic [2:0] setM;
    logic [3:0] clr;
    item_t      it;
    #1;
    g = modelGrant();
    check({tag, " grant"}, {1'b0, fetchEn}, {1'b0, g});
    gen = busErr || uncorrErr ||
          (descValid && ((descReady && descLen == 0) || descAddr[31:28] != 0));
    setM = gen ? 3'b111 : ((descValid && !descReady) ? g : 3'b000);
    clr = regWr ? regWdata : 4'b0;
    mHalt   = (mHalt & ~clr[2:0]) | setM;
    mSticky = (mSticky & ~clr[3]) | gen;
    it.status = {mSticky, mHalt};
    it.pulse  = gen;
    it.tag    = tag;
    sbq.push_back(it);
    @(negedge clk);
    descValid = 0; busErr = 0; uncorrErr = 0; regWr = 0; regWdata = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check({it.tag, " status"}, statusWord, it.status);
      check({it.tag, " pulse"}, {3'b0, txErrPulse}, {3'b0, it.pulse});
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R1 reset status", statusWord, 4'b0);
    check("R1 reset pulse", {3'b0, txErrPulse}, 4'b0);

    // R9 priority
    ringEn = 3'b111; step("R9 all enabled");
    ringEn = 3'b110; step("R9 ring1 first");
    ringEn = 3'b100; step("R9 ring2 only");
    ringEn = 3'b000; step("R9 none enabled");

    // R5 no-ready descriptor halts granted ring only
    ringEn = 3'b111;
    descValid = 1; descReady = 0; descLen = 64; descAddr = 32'h100;
    step("R5 no ready on ring0");
    step("R2 ring0 halted skipped");

    // R3 write zero then write one
    regWr = 1; regWdata = 4'b0000; step("R3 write zero no effect");
    regWr = 1; regWdata = 4'b0001; step("R3 w1c ring0");

    // R6 graceful stop
    gracefulStop = 1; step("R6 stop no grant");
    descValid = 1; descReady = 0; step("R6 no-ready during stop sets nothing");
    gracefulStop = 0;

    // R4 zero length with rings disabled
    ringEn = 3'b000;
    descValid = 1; descReady = 1; descLen = 0; step("R4 R7 zero length halts all");
    step("R7 pulse one cycle");
    regWr = 1; regWdata = 4'b1111; step("R7 R3 clear all");

    // R4 bus error during graceful stop
    ringEn = 3'b111; gracefulStop = 1;
    busErr = 1; step("R4 bus error during stop");
    gracefulStop = 0;

    // R8 set beats clear
    regWr = 1; regWdata = 4'b1111; uncorrErr = 1; step("R8 set wins over clear");
    regWr = 1; regWdata = 4'b1111; step("R3 clear after set");

    // R4 address window
    descValid = 1; descReady = 1; descLen = 100; descAddr = 32'h0FFF_FFF0;
    step("R4 valid address no halt");
    descValid = 1; descReady = 1; descLen = 100; descAddr = 32'h1000_0000;
    step("R4 invalid address halts all");
    regWr = 1; regWdata = 4'b0110; step("R3 partial clear");
    step("R2 R9 grant ring1");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule